// File: doc/BRIEF.md
# Keyed Write-Protection Gate

This block guards the configuration registers of a timekeeping peripheral. It watches every write on the register bus. For each write it produces a write strobe for the addressed register, and that strobe is set only when the write may take effect. Writes to the clock-configuration registers (time, date, control, prescaler and alarm) are held back while protection is armed. The status register stays writable so that software can always clear event flags. Any other address outside the protected list and the key register also passes through.

To drop the protection, software writes two key values to a dedicated key register, 0xCA first and then 0x53. Writing any other value to the key register arms the protection again at once, and so does a value out of sequence. After reset the block is locked. A write that is blocked is simply not strobed: the target register keeps its value and no error is raised.

Top module: `wprot_gate`

## Requirements
- R1: After reset `prot_open` is 0, and a write to any protected address gives `wr_grant` = 0.
- R2: A key-register write of 0x000000CA followed later by a key-register write of 0x00000053 sets `prot_open` to 1, starting in the cycle after the second write. The whole 32-bit word is compared.
- R3: Bus cycles that are not key-register writes leave the key sequence where it stands. This covers idle cycles and writes to other addresses.
- R4: While locked, or after only the first key, a key-register write of any value other than the expected key returns the gate to locked. A second key that arrives without a valid first key just before it does not unlock.
- R5: While unlocked, any key-register write clears `prot_open` in the next cycle. A value of 0xCA also counts as the first key of a new sequence.
- R6: A write to a protected address (defaults 0x00, 0x04, 0x08, 0x0C, 0x10) raises `wr_grant` in the same cycle if and only if `prot_open` is 1.
- R7: A write to any address that is neither protected nor the key register (the status register at 0x14 among them) always raises `wr_grant` in the same cycle.
- R8: A write to the key register (default 0x18) never raises `wr_grant`.
- R9: `wr_grant` is 0 whenever `bus_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe of the register bus |
| bus_addr | input | 8 | Byte address of the write |
| bus_wdata | input | 32 | Write data |
| wr_grant | output | 1 | Qualified write strobe for the addressed register |
| prot_open | output | 1 | 1 while protected registers are writable |

## Verification
`wr_grant` is combinational from the current bus cycle and the current key state, so it is due in the cycle of the write itself. The bench drives each write on the falling edge and samples the grant one time step later, before the rising edge. `prot_open` is registered, so a key write changes it only after the next rising edge. The bench therefore checks it at the falling edge that follows, against a model state that it advances once per clock. The internal reset release takes two clocks, and the bench waits for that before it applies any key.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_HALF   = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_t;
endpackage

// File: rtl/wprot_rst_sync.sv
module wprot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wprot_addr_dec.sv
module wprot_addr_dec #(
  parameter int                          ADDR_W     = 8,
  parameter int                          NUM_PROT   = 5,
  parameter logic [NUM_PROT*ADDR_W-1:0]  PROT_ADDRS = '0,
  parameter logic [ADDR_W-1:0]           KEY_ADDR   = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_prot,
  output logic              is_key
);
  logic [NUM_PROT-1:0] hit;

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_cmp
    assign hit[i] = (addr == PROT_ADDRS[i*ADDR_W +: ADDR_W]);
  end

  assign is_prot = |hit;
  assign is_key  = (addr == KEY_ADDR);
endmodule

// File: rtl/wprot_key_fsm.sv
module wprot_key_fsm
  import wprot_pkg::*;
#(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_A  = 32'h0000_00CA,
  parameter logic [DATA_W-1:0] KEY_B  = 32'h0000_0053
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              open
);
  gate_state_t state_q, state_d;
  logic        state_en;

  always_comb begin
    state_d  = state_q;
    state_en = key_wr;
    if (key_wr) begin
      unique case (state_q)
        GATE_LOCKED: state_d = (key_data == KEY_A) ? GATE_HALF : GATE_LOCKED;
        GATE_HALF:   state_d = (key_data == KEY_B) ? GATE_OPEN : GATE_LOCKED;
        GATE_OPEN:   state_d = (key_data == KEY_A) ? GATE_HALF : GATE_LOCKED;
        default:     state_d = GATE_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= GATE_LOCKED;
    else if (state_en) state_q <= state_d;
  end

  assign open = (state_q == GATE_OPEN);

  // R2: unlocking only follows a second key written in the half state
  a_r2_open_by_key_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(key_wr && key_data == KEY_B && state_q == GATE_HALF));

  // R4: a wrong key never leaves the gate unlocked
  a_r4_wrong_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != KEY_A && key_data != KEY_B) |=> state_q == GATE_LOCKED);

  // R5: any key write while unlocked closes the gate
  a_r5_open_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && open) |=> !open);

  // R3: without a key write the sequence state holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(state_q));
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int                          ADDR_W     = 8,
  parameter int                          DATA_W     = 32,
  parameter int                          NUM_PROT   = 5,
  parameter logic [NUM_PROT*ADDR_W-1:0]  PROT_ADDRS = {8'h10, 8'h0C, 8'h08, 8'h04, 8'h00},
  parameter logic [ADDR_W-1:0]           KEY_ADDR   = 8'h18,
  parameter logic [DATA_W-1:0]           KEY_A      = 32'h0000_00CA,
  parameter logic [DATA_W-1:0]           KEY_B      = 32'h0000_0053
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wr_grant,
  output logic              prot_open
);
  logic rst_n_sync;
  logic is_prot, is_key;
  logic key_wr;

  wprot_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  wprot_addr_dec #(
    .ADDR_W     (ADDR_W),
    .NUM_PROT   (NUM_PROT),
    .PROT_ADDRS (PROT_ADDRS),
    .KEY_ADDR   (KEY_ADDR)
  ) u_dec (
    .addr    (bus_addr),
    .is_prot (is_prot),
    .is_key  (is_key)
  );

  assign key_wr = bus_wr & is_key;

  wprot_key_fsm #(
    .DATA_W (DATA_W),
    .KEY_A  (KEY_A),
    .KEY_B  (KEY_B)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .open     (prot_open)
  );

  always_comb begin
    wr_grant = 1'b0;
    if (bus_wr && !is_key) wr_grant = is_prot ? prot_open : 1'b1;
  end

  // R6: protected writes are blocked while locked
  a_r6_block_locked: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_wr && is_prot && !prot_open) |-> !wr_grant);

  // R7: unprotected, non-key addresses always pass
  a_r7_pass_unprot: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_wr && !is_prot && !is_key) |-> wr_grant);

  // R8: the key register is never strobed
  a_r8_key_no_grant: assert property (@(posedge clk) disable iff (!rst_n_sync)
    is_key |-> !wr_grant);

  // R9: no strobe without a bus write
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !bus_wr |-> !wr_grant);
endmodule

// File: tb/wprot_gate_bench.sv
`timescale 1ns/1ps
module wprot_gate_bench;
  localparam logic [7:0]  KEY_ADR = 8'h18;
  localparam logic [31:0] KA = 32'h0000_00CA;
  localparam logic [31:0] KB = 32'h0000_0053;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        wr_grant, prot_open;

  int checks = 0;
  int fails  = 0;
  int mst    = 0;  // model state: 0 locked, 1 half, 2 open

  always #5 clk = ~clk;

  wprot_gate u_wprot_gate (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wr_grant(wr_grant), .prot_open(prot_open)
  );

  function automatic bit prot_f(input logic [7:0] a);
    return (a == 8'h00) || (a == 8'h04) || (a == 8'h08) || (a == 8'h0C) || (a == 8'h10);
  endfunction

  function automatic bit grant_f(input bit wr, input logic [7:0] a, input int st);
    if (!wr || a == KEY_ADR) return 1'b0;
    if (prot_f(a)) return (st == 2);
    return 1'b1;
  endfunction

  function automatic int next_f(input int st, input bit wr, input logic [7:0] a,
                                input logic [31:0] d);
    if (!wr || a != KEY_ADR) return st;
    if (st == 1) return (d == KB) ? 2 : 0;
    return (d == KA) ? 1 : 0;
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (addr %02h data %08h)",
               req, got, exp, bus_addr, bus_wdata);
    end
  endtask

  // one bus cycle: drive at falling edge, check grant, then state after the edge
  task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input string req);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    check({req, " grant"}, wr_grant, grant_f(wr, a, mst));
    mst = next_f(mst, wr, a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    check({req, " open"}, prot_open, mst == 2);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 reset open", prot_open, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 open after release", prot_open, 1'b0);
    cyc(1, 8'h08, 32'h1, "R1 protected blocked");
    cyc(1, 8'h14, 32'h0, "R7 status passes");
    cyc(0, 8'h00, 32'h0, "R9 idle");
    // R2 with R3 gaps between keys
    cyc(1, KEY_ADR, KA, "R2 key A");
    cyc(1, 8'h14, 32'h5, "R3 status between keys");
    cyc(0, 8'h04, 32'h0, "R3 idle between keys");
    cyc(1, KEY_ADR, KB, "R2 key B");
    cyc(1, 8'h00, 32'h123, "R6 protected granted");
    cyc(1, 8'h10, 32'h7, "R6 prescaler granted");
    cyc(1, KEY_ADR, KA, "R8 key write not granted");
    // R5 relock then continue sequence from that KA
    cyc(1, KEY_ADR, KB, "R5 reopen from new key A");
    cyc(1, KEY_ADR, 32'hFF, "R5 lock value");
    cyc(1, 8'h0C, 32'h1, "R5 blocked after lock");
    // R4 wrong value after key A, then key B alone
    cyc(1, KEY_ADR, KA, "R4 key A");
    cyc(1, KEY_ADR, 32'h77, "R4 wrong value");
    cyc(1, KEY_ADR, KB, "R4 key B alone");
    cyc(1, KEY_ADR, KA, "R4 key A");
    cyc(1, KEY_ADR, KA, "R4 key A twice");
    cyc(1, KEY_ADR, KB, "R4 key B after repeat");
    // R2 upper bits compared
    cyc(1, KEY_ADR, 32'h0100_00CA, "R2 wide word not key");
    cyc(1, KEY_ADR, KB, "R2 no open");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0]  a;
      logic [31:0] d;
      bit wr = ($urandom_range(0, 4) != 0);
      case (sel)
        0, 1, 2: a = KEY_ADR;
        3, 4, 5: a = 8'(4 * $urandom_range(0, 4));
        6:       a = 8'h14;
        default: a = 8'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: d = KA;
        1: d = KB;
        2: d = 32'hFF;
        default: d = $urandom;
      endcase
      cyc(wr, a, d, "R6 R7 R8 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule